// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle in which `op_valid` is high, it takes a data operand (a memory byte or an immediate), the current accumulator value and a 4-bit operation code. It computes an 8-bit result and on the next clock edge it presents the result together with a one-cycle write strobe that names where the result goes: the accumulator or memory. The sequencer that owns the accumulator and the data memory acts on that strobe.

The block keeps the machine's 6-bit status word. It holds carry (C), half carry (AC), zero (Z) and overflow (OV), plus two power-state bits (TO, PDF) that no ALU operation touches. The incoming carry for add-with-carry, subtract-with-borrow and the rotates through carry is the C bit held in this register. Each operation class updates only its own subset of flags. Subtraction takes the accumulator from the operand and follows the "C means no borrow" convention. A decimal-adjust operation corrects the accumulator after a BCD addition and writes the corrected value to memory.

Top module: `acc_alu`

## Requirements
- R1: After reset, `status` reads 00h, `result` reads 00h, and `wr_acc` and `wr_mem` are both low.
- R2: Codes 0 (add: operand+acc) and 1 (add with carry: operand+acc+C) set C to the carry out of bit 7, AC to the carry out of bit 3, OV to the carry into bit 7 XOR the carry out of bit 7, and Z when the 8-bit result is zero.
- R3: Codes 2 (operand−acc) and 3 (operand−acc−(not C)) set C when there is no borrow (cleared when the true difference is negative), AC when the low nibble produces no borrow, OV on signed overflow of the difference, and Z on a zero result.
- R4: Codes 4 (AND), 5 (OR), 6 (XOR), 7 (operand+1), 8 (operand−1) and 14 (bitwise inverse of operand) compute their results modulo 256 and change only Z.
- R5: Codes 9 (rotate right), 10 (rotate left) and 13 (exchange the two nibbles of the operand) change no flag.
- R6: Code 11 rotates right through carry (bit 0 goes to C, old C goes to bit 7). Code 12 rotates left through carry (bit 7 goes to C, old C goes to bit 0). Only C changes.
- R7: Code 15 adjusts acc for decimal: it adds 06h when the low nibble is above 9 or AC=1. On that intermediate value, it then adds 60h when an 8-bit carry arose, the high nibble is above 9, or C=1. C becomes 1 exactly when the 60h step is applied, and no other flag changes (29h+35h=5Eh adjusts to 64h with C=0).
- R8: With `dst_mem`=0 a valid operation pulses `wr_acc`, and with `dst_mem`=1 it pulses `wr_mem`. Code 15 always pulses `wr_mem`. Exactly one strobe is high in the cycle after a valid operation.
- R9: A cycle with `op_valid` low raises no strobe and leaves `result` and `status` unchanged.
- R10: The status layout is bit5 TO, bit4 PDF, bit3 OV, bit2 Z, bit1 AC, bit0 C. Bits 7:6 read 0, and TO and PDF keep their reset value 0 through every operation.
- R11: The result, the strobe and the updated flags all appear at the ports on the first clock edge after the cycle in which the operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| dst_mem | input | 1 | 1: result to memory, 0: result to accumulator |
| operand | input | 8 | Memory byte or immediate |
| acc | input | 8 | Current accumulator value |
| result | output | 8 | Registered result |
| wr_acc | output | 1 | One-cycle accumulator write strobe |
| wr_mem | output | 1 | One-cycle memory write strobe |
| status | output | 8 | Status word {2'b00, TO, PDF, OV, Z, AC, C} |

## Verification
The only state in the block is the status word, and the ports show it in the cycle after every operation. A wrong carry or half-carry bit therefore shows up at once in `status`. It also shows up one operation later as a wrong result of add-with-carry, subtract-with-borrow, a rotate through carry or the decimal adjust, because each of these uses that bit. A flag that an operation class should leave alone but disturbs shows up as a `status` change on the next edge. Random chains of operations carry each flag error forward into later results, and directed cases cover the carry, borrow, overflow and decimal boundaries.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW = 8;          // data width
    localparam int NW = DW / 2;     // nibble width
    localparam int OPW = 4;         // op code width

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_ROR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_RRC  = 4'd11,
        OP_RLC  = 4'd12,
        OP_SWAP = 4'd13,
        OP_CPL  = 4'd14,
        OP_DAA  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic to;
        logic pdf;
        logic ov;
        logic z;
        logic ac;
        logic c;
    } stat_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wa;
        logic          wm;
        stat_t         st;
    } alu_state_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         c_nib,
    output logic         c_msb
);
    localparam int HW = W / 2;

    logic [HW:0] lo_sum;
    logic [W-1:0] sub_msb;
    logic [W:0]  full;

    always_comb begin
        lo_sum  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        sub_msb = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, cin};
        full    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum     = full[W-1:0];
        c_out   = full[W];
        c_nib   = lo_sum[HW];
        c_msb   = sub_msb[W-1];
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] val,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        res  = val;
        cout = cin;
        unique case (op)
            OP_ROR:  res = {val[0], val[DW-1:1]};
            OP_ROL:  res = {val[DW-2:0], val[DW-1]};
            OP_RRC:  begin res = {cin, val[DW-1:1]}; cout = val[0];    end
            OP_RLC:  begin res = {val[DW-2:0], cin}; cout = val[DW-1]; end
            OP_SWAP: res = {val[NW-1:0], val[DW-1:NW]};
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic          ac,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
    localparam logic [NW-1:0] FIX       = NW'(6);

    logic          lo_fix;
    logic          hi_fix;
    logic [DW:0]   step;

    always_comb begin
        lo_fix = (val[NW-1:0] > DIGIT_MAX) || ac;
        step   = {1'b0, val} + {{(DW-NW+1){1'b0}}, (lo_fix ? FIX : {NW{1'b0}})};
        hi_fix = step[DW] || (step[DW-1:NW] > DIGIT_MAX) || cin;
        res    = step[DW-1:0] + {(hi_fix ? FIX : {NW{1'b0}}), {NW{1'b0}}};
        cout   = hi_fix;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic           dst_mem,
    input  logic [DW-1:0]  operand,
    input  logic [DW-1:0]  acc,
    output logic [DW-1:0]  result,
    output logic           wr_acc,
    output logic           wr_mem,
    output logic [7:0]     status
);
    alu_state_t s_d, s_q;
    alu_op_e    op;

    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_co, add_cn, add_cm;
    logic [DW-1:0] sh_res;
    logic          sh_co;
    logic [DW-1:0] bcd_res;
    logic          bcd_co;

    assign op = alu_op_e'(op_code);

    always_comb begin
        add_b   = (op == OP_SUB || op == OP_SBC) ? ~acc : acc;
        unique case (op)
            OP_ADC, OP_SBC: add_cin = s_q.st.c;
            OP_SUB:         add_cin = 1'b1;
            default:        add_cin = 1'b0;
        endcase
    end

    acc_alu_adder #(.W(DW)) u_adder (
        .a(operand), .b(add_b), .cin(add_cin),
        .sum(add_sum), .c_out(add_co), .c_nib(add_cn), .c_msb(add_cm)
    );

    acc_alu_shift u_shift (
        .op(op), .val(operand), .cin(s_q.st.c), .res(sh_res), .cout(sh_co)
    );

    acc_alu_bcd u_bcd (
        .val(acc), .ac(s_q.st.ac), .cin(s_q.st.c), .res(bcd_res), .cout(bcd_co)
    );

    always_comb begin
        s_d    = s_q;
        s_d.wa = 1'b0;
        s_d.wm = 1'b0;
        if (op_valid) begin
            s_d.wa = !dst_mem && (op != OP_DAA);
            s_d.wm = dst_mem || (op == OP_DAA);
            unique case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                    s_d.res   = add_sum;
                    s_d.st.c  = add_co;
                    s_d.st.ac = add_cn;
                    s_d.st.ov = add_cm ^ add_co;
                    s_d.st.z  = (add_sum == '0);
                end
                OP_AND: s_d.res = operand & acc;
                OP_OR:  s_d.res = operand | acc;
                OP_XOR: s_d.res = operand ^ acc;
                OP_INC: s_d.res = operand + DW'(1);
                OP_DEC: s_d.res = operand - DW'(1);
                OP_CPL: s_d.res = ~operand;
                OP_ROR, OP_ROL, OP_SWAP: s_d.res = sh_res;
                OP_RRC, OP_RLC: begin
                    s_d.res  = sh_res;
                    s_d.st.c = sh_co;
                end
                OP_DAA: begin
                    s_d.res  = bcd_res;
                    s_d.st.c = bcd_co;
                end
                default: ;
            endcase
            if (op inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_CPL})
                s_d.st.z = (s_d.res == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result = s_q.res;
    assign wr_acc = s_q.wa;
    assign wr_mem = s_q.wm;
    assign status = {2'b00, s_q.st};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> $countones({wr_acc, wr_mem}) == 1);                          // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !wr_acc && !wr_mem && $stable(status) && $stable(result));  // R9
    AST_DAA_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_DAA |=> wr_mem && $stable(status[5:1]));        // R7
    AST_ROT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_ROR || op_code == OP_ROL || op_code == OP_SWAP)
        |=> $stable(status));                                                     // R5
    AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code <= OP_DEC || op_code == OP_CPL)
        |=> status[2] == (result == '0));                                         // R4
    AST_PWR_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'b0000);                                                  // R10
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic       dst_mem = 1'b0;
    logic [7:0] operand = '0;
    logic [7:0] acc = '0;
    logic [7:0] result;
    logic       wr_acc, wr_mem;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0] m_st = '0;   // {TO,PDF,OV,Z,AC,C}
    logic [7:0] m_res = '0;

    always #2.5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .dst_mem(dst_mem), .operand(operand), .acc(acc), .result(result),
        .wr_acc(wr_acc), .wr_mem(wr_mem), .status(status)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:                   return "R2";
            4'd2, 4'd3:                   return "R3";
            4'd9, 4'd10, 4'd13:           return "R5";
            4'd11, 4'd12:                 return "R6";
            4'd15:                        return "R7";
            default:                      return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model(input logic [3:0] op, input logic [7:0] m, input logic [7:0] a);
        int s, lo, cin;
        logic c, ac, z, ov;
        logic [7:0] r;
        c = m_st[0]; ac = m_st[1]; z = m_st[2]; ov = m_st[3];
        r = m_res;
        case (op)
            4'd0, 4'd1: begin
                cin = (op == 4'd1) ? int'(c) : 0;
                s  = int'(m) + int'(a) + cin;
                lo = int'(m & 8'h0f) + int'(a & 8'h0f) + cin;
                r  = s[7:0];
                c  = s > 255; ac = lo > 15;
                ov = ((m[7] == a[7]) && (r[7] != m[7]));
                z  = (r == 0);
            end
            4'd2, 4'd3: begin
                cin = (op == 4'd3) ? int'(!c) : 0;
                s  = int'(m) - int'(a) - cin;
                lo = int'(m & 8'h0f) - int'(a & 8'h0f) - cin;
                r  = s[7:0];
                c  = s >= 0; ac = lo >= 0;
                ov = ((m[7] != a[7]) && (r[7] != m[7]));
                z  = (r == 0);
            end
            4'd4:  begin r = m & a; z = (r == 0); end
            4'd5:  begin r = m | a; z = (r == 0); end
            4'd6:  begin r = m ^ a; z = (r == 0); end
            4'd7:  begin r = m + 8'd1; z = (r == 0); end
            4'd8:  begin r = m - 8'd1; z = (r == 0); end
            4'd14: begin r = ~m; z = (r == 0); end
            4'd9:  r = {m[0], m[7:1]};
            4'd10: r = {m[6:0], m[7]};
            4'd13: r = {m[3:0], m[7:4]};
            4'd11: begin r = {c, m[7:1]}; c = m[0]; end
            4'd12: begin r = {m[6:0], c}; c = m[7]; end
            default: begin
                s = int'(a);
                if ((a[3:0] > 9) || ac) s = s + 6;
                if ((s > 255) || (((s >> 4) & 15) > 9) || c) begin
                    s = s + 'h60; c = 1'b1;
                end else c = 1'b0;
                r = s[7:0];
            end
        endcase
        m_res = r;
        m_st  = {2'b00, ov, z, ac, c};
    endtask

    task automatic do_op(input logic [3:0] op, input logic dm,
                         input logic [7:0] m, input logic [7:0] a);
        logic ew_acc, ew_mem;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; dst_mem = dm; operand = m; acc = a;
        @(negedge clk);
        op_valid = 1'b0;
        operand = ~m; acc = ~a;  // idle-cycle inputs must not matter
        model(op, m, a);
        ew_mem = dm || (op == 4'd15);
        ew_acc = !ew_mem;
        // R11: everything visible right after the first edge
        check(tag_of(op), {16'h0, status, result}, {16'h0, 2'b00, m_st, m_res});
        check("R8", {30'h0, wr_acc, wr_mem}, {30'h0, ew_acc, ew_mem});
        check("R10", {28'h0, status[7:4]}, 32'h0);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R9", {14'h0, wr_acc, wr_mem, status, result}, {16'h0, 2'b00, m_st, m_res});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1
        check("R1", {16'h0, status, result}, 32'h0);
        check("R1", {30'h0, wr_acc, wr_mem}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {16'h0, status, result}, 32'h0);

        // R2 directed: carry, half carry, zero
        do_op(4'd0, 1'b0, 8'hFF, 8'h01);
        do_op(4'd1, 1'b1, 8'h10, 8'h20);   // carry-in 1 -> 31h
        do_op(4'd0, 1'b0, 8'h7F, 8'h01);   // OV set
        do_op(4'd0, 1'b0, 8'h80, 8'h80);   // OV, C, Z
        // R3 directed
        do_op(4'd2, 1'b0, 8'h05, 8'h03);   // no borrow: C=1
        do_op(4'd2, 1'b0, 8'h03, 8'h05);   // borrow: C=0
        do_op(4'd3, 1'b1, 8'h10, 8'h0F);   // C=0 so extra borrow -> 00h
        do_op(4'd2, 1'b0, 8'h80, 8'h01);   // signed overflow
        // R6 directed
        do_op(4'd0, 1'b0, 8'hF0, 8'h20);   // C=1
        do_op(4'd11, 1'b0, 8'h02, 8'h00);  // old C to bit7, bit0=0 to C
        do_op(4'd12, 1'b0, 8'h81, 8'h00);
        // R7 directed: 29h+35h then adjust -> 64h
        do_op(4'd0, 1'b0, 8'h29, 8'h35);
        do_op(4'd15, 1'b0, 8'h00, 8'h5E);
        check("R7", {24'h0, result}, 32'h64);
        do_op(4'd0, 1'b0, 8'h99, 8'h01);   // 9Ah, AC=0
        do_op(4'd15, 1'b1, 8'h00, 8'h9A);  // -> 00h, C=1
        check("R7", {24'h0, result}, 32'h00);
        do_op(4'd0, 1'b0, 8'h08, 8'h08);   // 10h, AC=1
        do_op(4'd15, 1'b0, 8'h00, 8'h10);  // -> 16h
        // R5, R4, R9
        do_op(4'd13, 1'b0, 8'hA5, 8'h00);
        do_op(4'd9, 1'b1, 8'h01, 8'h00);
        do_op(4'd10, 1'b0, 8'h80, 8'h00);
        do_op(4'd8, 1'b0, 8'h01, 8'h00);   // Z
        do_op(4'd7, 1'b1, 8'hFF, 8'h00);   // wraps to 0, C kept
        do_op(4'd14, 1'b0, 8'hFF, 8'h00);
        idle_check();
        idle_check();

        // random chains
        for (int i = 0; i < 3000; i++) begin
            do_op(4'($urandom()), 1'($urandom()), 8'($urandom()), 8'($urandom()));
            if (($urandom() % 8) == 0) idle_check();
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R11 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule